// File: doc/BRIEF.md
# Triggered Programmable Interval Timer

This block is a synchronous interval timer. It pairs a small control state machine with a binary up-counter. A one-cycle tick strobe stands in for the time base. The counter moves by one only on a tick while the timer is running. Trigger and stop requests arrive as single-cycle pulses. Every counter bit drives its own active-low output. While the timer is idle, all of these outputs are forced high.

A select mask picks which outputs join a combined bus output. The bus is low whenever any selected output is low, so the selected bit weights add up to the length of the delay. A mode input is captured when the trigger is taken, and it picks between two behaviours:

- **One-shot:** the bus going high ends the cycle on its own.
- **Free-run:** the counter wraps until a stop pulse arrives.

A wrap strobe marks each 255-to-0 rollover. Feeding that strobe into the tick input of a second instance builds a 16-bit delay chain.

The control machine has three states: `ST_IDLE`, `ST_ONESHOT` and `ST_FREERUN`. It has four named transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| START | `ST_IDLE` | one-shot or free-run state, chosen by the mode input | a trigger arrives |
| RESTART | any running state | the state chosen by the mode input | a trigger arrives in the same cycle as a stop request |
| EXPIRE | `ST_ONESHOT` | `ST_IDLE` | the bus output is high |
| ABORT | either running state | `ST_IDLE` | a stop pulse arrives without a trigger |

Top module: `interval_timer`

## Requirements
- R1: During and after reset, the block is idle. All counter outputs are high, the bus output is high and the wrap strobe is low.
- R2: A trigger taken while idle clears the counter. From the next cycle on, all counter outputs are low.
- R3: With a tick in every cycle, output k stays low for exactly 2^k cycles after the trigger edge. Output k mirrors counter bit k while running, so j cycles after the trigger the outputs read j modulo 256.
- R4: The counter advances by one on each tick while running and holds when there is no tick. Ticks taken while idle leave the outputs all high.
- R5: A trigger taken while running, with no stop request in the same cycle, is ignored. Counting continues undisturbed.
- R6: A trigger in the same cycle as a stop request wins: the counter restarts from zero and keeps running. The stop request may come from the stop pulse or from one-shot expiry.
- R7: A stop pulse without a trigger returns the block to idle on the next edge, and all outputs go high.
- R8: The bus output is low whenever any output whose select bit (bit k selects output k) is set is low. In one-shot mode (mode input 0), the bus stays low for exactly the select value in ticks. The block is idle on the following edge.
- R9: An all-zero select keeps the bus high. In one-shot mode, a trigger then lasts a single cycle before the block returns to idle.
- R10: In free-run mode (mode input 1), the counter wraps from 255 to 0 and keeps running. The bus pattern repeats with the period of the highest selected bit.
- R11: The wrap strobe is high in the cycle where a tick meets a count of 255. A second instance ticked by this strobe finishes a one-shot of select value m after 256·m ticks.
- R12: The mode is captured when the trigger is taken. Changing the mode input while running does not change the behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, forces the idle state |
| tick_i | input | 1 | Time-base strobe; one count per high cycle |
| trig_i | input | 1 | Start pulse |
| clr_i | input | 1 | Stop pulse |
| mode_i | input | 1 | 0 = one-shot, 1 = free-run; captured when a trigger is taken |
| sel_i | input | 8 | Mask of outputs combined into the bus |
| out_n_o | output | 8 | Active-low counter outputs; bit k follows counter bit k while running |
| bus_n_o | output | 1 | Combined output; low while any selected output is low |
| wrap_o | output | 1 | High in the cycle the counter rolls from 255 to 0 |

## Verification
Trigger, stop and tick all act at the clock edge where they are sampled, so the counter outputs change one edge after the stimulus. The bus output and the wrap strobe are combinational on that registered state. One-shot expiry takes one more edge: the bus reads high for one cycle, and idle follows on the next edge. The bench drives each input just after a rising edge and reads outputs one time unit after the next edge. It predicts the count as the number of tick edges since the trigger edge, and it measures bus-low spans in whole cycles, comparing them with the select value or with 256 times it for the chained pair.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ONESHOT = 2'd1,
        ST_FREERUN = 2'd2
    } ivt_state_e;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic trig_i,
    input  logic clr_i,
    input  logic mode_i,
    input  logic bus_n_i,
    output logic run_o,
    output logic load_o,
    output logic step_o
);
    ivt_state_e state_q, state_d;
    logic       running;
    logic       expire;
    logic       stop_req;
    logic       start;

    always_comb begin
        running  = (state_q != ST_IDLE);
        expire   = (state_q == ST_ONESHOT) && bus_n_i;
        stop_req = clr_i || expire;
        start    = trig_i && (!running || stop_req);
    end

    // next-state: START, RESTART, EXPIRE, ABORT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_i) state_d = mode_i ? ST_FREERUN : ST_ONESHOT;
            end
            ST_ONESHOT, ST_FREERUN: begin
                if (start)         state_d = mode_i ? ST_FREERUN : ST_ONESHOT;
                else if (stop_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs to counter and output stage
    always_comb begin
        run_o  = running;
        load_o = start || (running && stop_req);
        step_o = running && tick_i;
    end

    p_retrig_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && trig_i && !stop_req) |=> (state_q == $past(state_q)));

    p_trig_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && clr_i) |=> (state_q != ST_IDLE));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !trig_i) |=> (state_q == ST_IDLE));

    p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !trig_i) |=> (state_q == ST_IDLE));

    p_mode_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop_req) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + ONE;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = step_i && !load_i && (&cnt_q);

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (cnt_q == $past(cnt_q) + ONE));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(cnt_q));

    p_load_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == '0));

    p_wrap_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/ivt_outs.sv
module ivt_outs #(
    parameter int WIDTH = 8
) (
    input  logic             run_i,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic [WIDTH-1:0] sel_i,
    output logic [WIDTH-1:0] out_n_o,
    output logic             bus_n_o
);
    logic [WIDTH-1:0] lane_hi;

    for (genvar k = 0; k < WIDTH; k++) begin : g_lane
        assign out_n_o[k] = run_i ? cnt_i[k] : 1'b1;
        assign lane_hi[k] = out_n_o[k] || !sel_i[k];
    end

    assign bus_n_o = &lane_hi;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             trig_i,
    input  logic             clr_i,
    input  logic             mode_i,
    input  logic [WIDTH-1:0] sel_i,
    output logic [WIDTH-1:0] out_n_o,
    output logic             bus_n_o,
    output logic             wrap_o
);
    logic             run;
    logic             load;
    logic             step;
    logic [WIDTH-1:0] cnt;

    ivt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .trig_i  (trig_i),
        .clr_i   (clr_i),
        .mode_i  (mode_i),
        .bus_n_i (bus_n_o),
        .run_o   (run),
        .load_o  (load),
        .step_o  (step)
    );

    ivt_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .cnt_o  (cnt),
        .wrap_o (wrap_o)
    );

    ivt_outs #(.WIDTH(WIDTH)) u_outs (
        .run_i   (run),
        .cnt_i   (cnt),
        .sel_i   (sel_i),
        .out_n_o (out_n_o),
        .bus_n_o (bus_n_o)
    );

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> ((&out_n_o) && bus_n_o && !wrap_o));

    p_bus_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_n_o |-> ((~out_n_o & sel_i) != '0));

    p_sel_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0) |-> bus_n_o);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && trig_i) |=> (out_n_o == '0));
endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       trig = 1'b0;
    logic       clr = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] sel = 8'd0;
    logic [7:0] sel_hi = 8'd0;
    logic [7:0] out_n, out_n_hi;
    logic       bus_n, bus_n_hi, wrap, wrap_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .trig_i(trig), .clr_i(clr),
        .mode_i(mode), .sel_i(sel), .out_n_o(out_n), .bus_n_o(bus_n), .wrap_o(wrap)
    );

    interval_timer u_dut_hi (
        .clk(clk), .rst_n(rst_n), .tick_i(wrap), .trig_i(trig), .clr_i(clr),
        .mode_i(1'b0), .sel_i(sel_hi), .out_n_o(out_n_hi), .bus_n_o(bus_n_hi),
        .wrap_o(wrap_hi)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        cyc();
        trig = 1'b0;
    endtask

    task automatic stop();
        clr = 1'b1;
        cyc();
        clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int expv;
        int low;
        #1;
        repeat (3) cyc();
        check("R1 outputs in reset", int'(out_n), 255);
        check("R1 bus in reset", int'(bus_n), 1);
        rst_n = 1'b1;
        cyc();
        check("R1 outputs after reset", int'(out_n), 255);
        check("R1 wrap after reset", int'(wrap), 0);

        // R4: idle ticks ignored
        tick = 1'b1;
        repeat (5) cyc();
        check("R4 idle ticks", int'(out_n), 255);

        // R3 / R10 / R11: free-run sweep with tick every cycle
        mode = 1'b1;
        sel = 8'd0;
        pulse_trig();
        for (int j = 0; j < 300; j++) begin
            check(j < 256 ? "R3 output weights" : "R10 wrap continues", int'(out_n), j % 256);
            check("R11 wrap strobe", int'(wrap), (j % 256 == 255) ? 1 : 0);
            cyc();
        end
        stop();
        check("R7 stop to idle", int'(out_n), 255);

        // R10: bus pattern of bits 1 and 3
        sel = 8'h0A;
        pulse_trig();
        for (int j = 0; j < 64; j++) begin
            expv = ((((j % 256) | ~32'h0A) & 32'hFF) == 32'hFF) ? 1 : 0;
            check("R10 bus pattern", int'(bus_n), expv);
            cyc();
        end
        stop();

        // R12: mode captured at trigger
        sel = 8'd1;
        mode = 1'b1;
        pulse_trig();
        mode = 1'b0;
        repeat (3) cyc();
        check("R12 mode held", int'(out_n), 3);
        stop();

        // R4: gapped ticks
        mode = 1'b1;
        sel = 8'd0;
        tick = 1'b0;
        pulse_trig();
        expv = 0;
        for (int i = 0; i < 30; i++) begin
            tick = (i % 3 == 0);
            cyc();
            if (i % 3 == 0) expv++;
            check("R4 gapped ticks", int'(out_n), expv);
        end
        // R5: retrigger ignored
        tick = 1'b1;
        trig = 1'b1;
        cyc();
        trig = 1'b0;
        check("R5 retrigger ignored", int'(out_n), expv + 1);
        // R6: trigger and stop together
        trig = 1'b1;
        clr = 1'b1;
        cyc();
        trig = 1'b0;
        clr = 1'b0;
        check("R6 trigger wins", int'(out_n), 0);
        cyc();
        check("R6 still running", int'(out_n), 1);
        stop();
        check("R7 stop clears", int'(out_n), 255);
        cyc();
        check("R7 stays idle", int'(out_n), 255);

        // R8: one-shot sweep of every nonzero select
        mode = 1'b0;
        tick = 1'b1;
        for (int n = 1; n < 256; n++) begin
            sel = n[7:0];
            pulse_trig();
            check("R2 trigger clears", int'(out_n), 0);
            low = 0;
            while (bus_n == 1'b0 && low < 300) begin
                low++;
                cyc();
            end
            check("R8 one-shot length", low, n);
            cyc();
            check("R8 returns idle", int'(out_n), 255);
        end

        // R9: zero select
        sel = 8'd0;
        pulse_trig();
        check("R9 running one cycle", int'(out_n), 0);
        check("R9 bus high", int'(bus_n), 1);
        cyc();
        check("R9 back to idle", int'(out_n), 255);

        // R6: trigger in the expiry cycle restarts
        sel = 8'd2;
        pulse_trig();
        repeat (2) cyc();
        check("R6 expiry cycle bus", int'(bus_n), 1);
        trig = 1'b1;
        cyc();
        trig = 1'b0;
        check("R6 restart on expiry", int'(out_n), 0);
        stop();

        // R11: cascade
        mode = 1'b1;
        sel = 8'd0;
        for (int m = 1; m <= 3; m += 2) begin
            sel_hi = m[7:0];
            stop();
            pulse_trig();
            low = 0;
            while (bus_n_hi == 1'b0 && low < 1000) begin
                low++;
                cyc();
            end
            check("R11 cascade length", low, 256 * m);
        end
        stop();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule